// File: doc/BRIEF.md
# Signed Chroma Delay Aligner

This block lines a chroma sample stream up with its luma stream when the two have arrived through paths of different length. Luma always passes through a fixed two-clock pipeline. Chroma runs through a short shift register whose output tap is chosen by a small signed code. Because luma already carries a nominal latency of two clocks, the chroma tap can sit up to two clocks earlier or one clock later than luma. This gives a relative chroma shift of -2, -1, 0 or +1 clocks.

A one-bit Cb/Cr phase flag travels alongside each chroma sample through the same selected tap, so each sample keeps its own flag. An odd shift of a multiplexed Cb/Cr stream swaps the meaning of the flag, which shows up as reversed tint. For that case an inversion control flips the outgoing flag. The usual pairing is a shift of -1 clock with inversion set. The power-on setting is no shift and no inversion.

A build parameter selects one of two variants. The full variant decodes the whole 2-bit signed code. The reduced variant supports only "no shift" and "+1 clock". Each instance runs from one clock. The step size is whatever sample clock drives the instance.

Top module: `chroma_align`

## Requirements
- R1: While reset is held and on the first cycle after it, every pipeline stage reads as zero. Luma and chroma outputs are zero, and the flag output equals the inversion control.
- R2: Luma output equals the luma input from exactly 2 clocks earlier, whatever the delay code.
- R3: With delay code 2'b00, chroma output equals the chroma input from 2 clocks earlier, which is aligned with luma.
- R4: With delay code 2'b01, chroma output equals the chroma input from 3 clocks earlier, which is +1 clock relative to luma.
- R5: In the full variant, delay code 2'b10 gives chroma equal to the current chroma input, with no register stage (-2 clocks relative to luma).
- R6: In the full variant, delay code 2'b11 gives chroma equal to the chroma input from 1 clock earlier (-1 clock relative to luma).
- R7: The flag is taken from the same tap as the chroma sample, so the flag that leaves with a sample is the flag that entered with it.
- R8: When the inversion control is 1, the flag output is the complement of the tapped flag. When it is 0, the tapped flag passes unchanged.
- R9: In the reduced variant only bit 0 of the code matters: bit 0 = 1 gives +1 clock (latency 3) and bit 0 = 0 gives latency 2, and bit 1 has no effect.
- R10: A change of the delay code or the inversion control takes effect on the output in the same cycle it is applied. The shift register keeps running under every setting, so the newly chosen tap already holds valid history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| dly_code | input | 2 | Signed chroma shift code: 00 = 0, 01 = +1, 10 = -2, 11 = -1 |
| flag_inv | input | 1 | 1 inverts the outgoing Cb/Cr flag |
| chroma_i | input | CHROMA_W | Chroma sample in |
| cbcr_i | input | 1 | Cb/Cr phase flag of the chroma sample in |
| luma_i | input | LUMA_W | Luma sample in |
| luma_o | output | LUMA_W | Luma delayed by the nominal latency |
| chroma_o | output | CHROMA_W | Chroma from the selected tap |
| cbcr_o | output | 1 | Flag from the selected tap, optionally inverted |

## Verification
A stuck or mis-shifted stage in the chroma shift register appears at the chroma output as soon as the code selects that tap or a later one. Reaching the deepest tap takes at most three clocks after the fault. A wrong tap decode shows up in the very first sample after the code is applied, because it returns a neighbouring sample. Data that changes on every clock makes a one-clock error visible at once. A flag that has come apart from its sample, or a wrong inversion, shows up on the flag output in the same cycle. Running every code back to back, and switching codes cycle by cycle, therefore exposes any such fault within three clocks.

// File: rtl/chroma_align_pkg.sv
package chroma_align_pkg;

   // nominal luma latency; chroma taps span 0 .. NOM_LAT+1
   localparam int NOM_LAT = 2;
   localparam int MAX_LAT = NOM_LAT + 1;

   // full signed decode: relative shift {0,+1,-2,-1} around NOM_LAT
   function automatic int unsigned tap_full(input logic [1:0] code);
      int unsigned t;
      case (code)
         2'b00:   t = NOM_LAT;
         2'b01:   t = NOM_LAT + 1;
         2'b10:   t = NOM_LAT - 2;
         default: t = NOM_LAT - 1;
      endcase
      return t;
   endfunction

   // reduced decode: only bit 0 used, 0 or +1
   function automatic int unsigned tap_reduced(input logic [1:0] code);
      return code[0] ? NOM_LAT + 1 : NOM_LAT;
   endfunction

endpackage

// File: rtl/tapline.sv
module tapline #(
   parameter int W     = 8,
   parameter int DEPTH = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [W-1:0]            din,
   output logic [DEPTH:0][W-1:0]   taps
);

   initial begin
      assert (W > 0) else $error("tapline: W must be positive");
      assert (DEPTH > 0) else $error("tapline: DEPTH must be positive");
   end

   logic [DEPTH-1:0][W-1:0] stage;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage <= '0;
      end else begin
         stage[0] <= din;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   // tap 0 is the live input, tap k is the input k clocks ago
   assign taps = {stage, din};

endmodule

// File: rtl/tap_select.sv
module tap_select
   import chroma_align_pkg::*;
#(
   parameter int W          = 8,
   parameter int DEPTH      = 3,
   parameter bit FULL_RANGE = 1'b1
) (
   input  logic [DEPTH:0][W-1:0] taps,
   input  logic [1:0]            code,
   output logic [W-1:0]          word
);

   localparam int IW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= MAX_LAT) else $error("tap_select: DEPTH below deepest tap");
   end

   logic [IW-1:0] idx;

   generate
      if (FULL_RANGE) begin : g_full
         always_comb idx = IW'(tap_full(code));
      end else begin : g_reduced
         always_comb idx = IW'(tap_reduced(code));
      end
   endgenerate

   assign word = taps[idx];

endmodule

// File: rtl/chroma_align.sv
module chroma_align
   import chroma_align_pkg::*;
#(
   parameter int CHROMA_W   = 10,
   parameter int LUMA_W     = 10,
   parameter bit FULL_RANGE = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0]          dly_code,
   input  logic                flag_inv,
   input  logic [CHROMA_W-1:0] chroma_i,
   input  logic                cbcr_i,
   input  logic [LUMA_W-1:0]   luma_i,
   output logic [LUMA_W-1:0]   luma_o,
   output logic [CHROMA_W-1:0] chroma_o,
   output logic                cbcr_o
);

   localparam int PW     = CHROMA_W + 1;   // flag rides above the chroma bits
   localparam int CDEPTH = MAX_LAT;

   initial begin
      assert (CHROMA_W > 0 && LUMA_W > 0) else $error("chroma_align: widths must be positive");
   end

   logic [CDEPTH:0][PW-1:0]      c_taps;
   logic [NOM_LAT:0][LUMA_W-1:0] l_taps;
   logic [PW-1:0]                c_sel;

   // chroma and flag share one shift register so they stay paired
   tapline #(.W(PW), .DEPTH(CDEPTH)) u_ctap (
      .clk  (clk),
      .rst  (rst),
      .din  ({cbcr_i, chroma_i}),
      .taps (c_taps)
   );

   tapline #(.W(LUMA_W), .DEPTH(NOM_LAT)) u_ltap (
      .clk  (clk),
      .rst  (rst),
      .din  (luma_i),
      .taps (l_taps)
   );

   tap_select #(.W(PW), .DEPTH(CDEPTH), .FULL_RANGE(FULL_RANGE)) u_sel (
      .taps (c_taps),
      .code (dly_code),
      .word (c_sel)
   );

   assign luma_o   = l_taps[NOM_LAT];
   assign chroma_o = c_sel[CHROMA_W-1:0];
   assign cbcr_o   = c_sel[PW-1] ^ flag_inv;

   // cycles since reset, saturating, so $past never reaches into reset
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)               warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   a_r2_luma_lat: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3) |-> (luma_o == $past(luma_i, 2)));

   a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
      (dly_code == 2'b00 && warm == 2'd3) |-> (chroma_o == $past(chroma_i, 2)));

   a_r4_plus_one: assert property (@(posedge clk) disable iff (rst)
      (dly_code == 2'b01 && warm == 2'd3) |-> (chroma_o == $past(chroma_i, 3)));

   a_r7_flag_paired: assert property (@(posedge clk) disable iff (rst)
      (dly_code == 2'b01 && warm == 2'd3) |-> (cbcr_o == ($past(cbcr_i, 3) ^ flag_inv)));

   generate
      if (FULL_RANGE) begin : g_chk_full
         a_r5_minus_two: assert property (@(posedge clk) disable iff (rst)
            (dly_code == 2'b10) |-> (chroma_o == chroma_i));
         a_r8_invert: assert property (@(posedge clk) disable iff (rst)
            (dly_code == 2'b10) |-> (cbcr_o == (cbcr_i ^ flag_inv)));
         a_r6_minus_one: assert property (@(posedge clk) disable iff (rst)
            (dly_code == 2'b11 && warm != 2'd0) |-> (chroma_o == $past(chroma_i, 1)));
      end else begin : g_chk_reduced
         a_r9_bit1_ignored: assert property (@(posedge clk) disable iff (rst)
            (dly_code == 2'b10 && warm == 2'd3) |-> (chroma_o == $past(chroma_i, 2)));
      end
   endgenerate

endmodule

// File: tb/test_chroma_align.sv
module test_chroma_align;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 10;
   localparam int LW = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    dly_code = 2'b00;
   logic          flag_inv = 1'b0;
   logic [CW-1:0] chroma_i = '0;
   logic          cbcr_i = 1'b0;
   logic [LW-1:0] luma_i = '0;

   logic [LW-1:0] luma_o, n_luma_o;
   logic [CW-1:0] chroma_o, n_chroma_o;
   logic          cbcr_o, n_cbcr_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   chroma_align #(.CHROMA_W(CW), .LUMA_W(LW), .FULL_RANGE(1'b1)) i_chroma_align (
      .clk(clk), .rst(rst), .dly_code(dly_code), .flag_inv(flag_inv),
      .chroma_i(chroma_i), .cbcr_i(cbcr_i), .luma_i(luma_i),
      .luma_o(luma_o), .chroma_o(chroma_o), .cbcr_o(cbcr_o));

   chroma_align #(.CHROMA_W(CW), .LUMA_W(LW), .FULL_RANGE(1'b0)) i_narrow (
      .clk(clk), .rst(rst), .dly_code(dly_code), .flag_inv(flag_inv),
      .chroma_i(chroma_i), .cbcr_i(cbcr_i), .luma_i(luma_i),
      .luma_o(n_luma_o), .chroma_o(n_chroma_o), .cbcr_o(n_cbcr_o));

   typedef struct {
      logic [CW-1:0] c;
      logic          f;
      logic [LW-1:0] l;
      logic [CW-1:0] nc;
      logic          nf;
      string         tag;
   } exp_t;

   exp_t          exp_q[$];
   logic [CW-1:0] hist_c[$];
   logic          hist_f[$];
   logic [LW-1:0] hist_l[$];
   logic [1:0]    prev_code = 2'b00;
   int            n_checks = 0;
   int            n_errors = 0;
   bit            done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic int lat_full(input logic [1:0] code);
      case (code)
         2'b00:   return 2;
         2'b01:   return 3;
         2'b10:   return 0;
         default: return 1;
      endcase
   endfunction

   // driver: applies one sample and pushes the expected outputs
   task automatic step(input logic [CW-1:0] c, input logic f, input logic [LW-1:0] l,
                       input logic [1:0] code, input logic inv);
      exp_t e;
      int   lf, ln;
      @(posedge clk);
      #1;
      chroma_i = c; cbcr_i = f; luma_i = l; dly_code = code; flag_inv = inv;
      hist_c.push_front(c); hist_f.push_front(f); hist_l.push_front(l);
      if (hist_c.size() > 8) begin
         void'(hist_c.pop_back()); void'(hist_f.pop_back()); void'(hist_l.pop_back());
      end
      lf = lat_full(code);
      ln = code[0] ? 3 : 2;
      e.c  = hist_c[lf];
      e.f  = hist_f[lf] ^ inv;
      e.l  = hist_l[2];
      e.nc = hist_c[ln];
      e.nf = hist_f[ln] ^ inv;
      case (code)
         2'b00:   e.tag = "R3";
         2'b01:   e.tag = "R4";
         2'b10:   e.tag = "R5";
         default: e.tag = "R6";
      endcase
      if (code != prev_code) e.tag = {e.tag, "/R10"};
      prev_code = code;
      exp_q.push_back(e);
   endtask

   // monitor: compares away from the active edge
   always @(negedge clk) begin
      if (!rst && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(chroma_o == e.c, e.tag, "chroma", 32'(chroma_o), 32'(e.c));
         check(cbcr_o == e.f, flag_inv ? "R8/R7" : "R7", "flag", 32'(cbcr_o), 32'(e.f));
         check(luma_o == e.l, "R2", "luma", 32'(luma_o), 32'(e.l));
         check(n_chroma_o == e.nc, "R9", "reduced chroma", 32'(n_chroma_o), 32'(e.nc));
         check(n_cbcr_o == e.nf, "R9", "reduced flag", 32'(n_cbcr_o), 32'(e.nf));
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         hist_c.push_front('0); hist_f.push_front(1'b0); hist_l.push_front('0);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: cleared stages, flag follows inversion control
      check(chroma_o == '0, "R1", "chroma in reset", 32'(chroma_o), 0);
      check(luma_o == '0, "R1", "luma in reset", 32'(luma_o), 0);
      check(cbcr_o == 1'b0, "R1", "flag in reset", 32'(cbcr_o), 0);
      flag_inv = 1'b1;
      #1;
      check(cbcr_o == 1'b1, "R1", "flag in reset inverted", 32'(cbcr_o), 1);
      flag_inv = 1'b0;
      @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      check(chroma_o == '0 && n_chroma_o == '0, "R1", "chroma after reset", 32'(chroma_o), 0);
      check(luma_o == '0, "R1", "luma after reset", 32'(luma_o), 0);

      // each code held over a run of changing data
      for (int k = 0; k < 10; k++) step(CW'($urandom), 1'(k), LW'($urandom), 2'b00, 1'b0);
      for (int k = 0; k < 10; k++) step(CW'($urandom), 1'(k), LW'($urandom), 2'b01, 1'b0);
      for (int k = 0; k < 10; k++) step(CW'($urandom), 1'(k), LW'($urandom), 2'b10, 1'b0);
      for (int k = 0; k < 10; k++) step(CW'($urandom), 1'(k), LW'($urandom), 2'b11, 1'b1);
      for (int k = 0; k < 10; k++) step(CW'($urandom), 1'($urandom), LW'($urandom), 2'b01, 1'b1);
      // R10: code and inversion change every cycle
      for (int k = 0; k < 40; k++)
         step(CW'($urandom), 1'($urandom), LW'($urandom), 2'($urandom), 1'($urandom));
      // walking ramp with every code in turn
      for (int k = 0; k < 16; k++) step(CW'(k * 37), 1'(k), LW'(k * 11), 2'(k), 1'(k >> 2));
      @(posedge clk);
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule